// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit

This block moves a data word by exactly one bit position in one of eight ways, picked by a 3-bit mode code. The same code also selects the ALU function in a small processor data path. The block takes the word, an external carry bit and the mode. It returns the moved word and the bit that fell off the end.

The unit is purely combinational. Its outputs follow its inputs with no clock and no stored state. The left-moving modes and the right-moving modes are built as two separate sub-units. The top selects between them, using the high bit of the mode code as the direction bit.

Top module: `step_shifter`

## Requirements
- R1: Mode 3'b000 returns data_in unchanged on data_out and drives carry_out to 0.
- R2: Mode 3'b001 rotates left by one: data_out[0] receives data_in[WIDTH-1], and carry_out equals data_in[WIDTH-1].
- R3: Mode 3'b010 moves left by one with 0 entering bit 0, and carry_out equals data_in[WIDTH-1].
- R4: Mode 3'b011 moves left by one with carry_in entering bit 0, and carry_out equals data_in[WIDTH-1].
- R5: Mode 3'b100 rotates right by one: data_out[WIDTH-1] receives data_in[0], and carry_out equals data_in[0].
- R6: Mode 3'b101 moves right by one with 0 entering the top bit, and carry_out equals data_in[0].
- R7: Mode 3'b110 moves right by one with the top bit of data_in kept in the top bit (sign replication), and carry_out equals data_in[0].
- R8: Mode 3'b111 moves right by one with carry_in entering the top bit, and carry_out equals data_in[0].
- R9: In every mode other than 3'b011 and 3'b111, carry_in has no effect on data_out or carry_out.
- R10: Outputs depend only on the present inputs, with no clock or stored state. The block is correct for any WIDTH of 2 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | WIDTH | Word to be moved |
| carry_in | input | 1 | External bit used as fill by modes 3'b011 and 3'b111 |
| mode | input | 3 | Operation code; bit 2 set selects a right move |
| data_out | output | WIDTH | Moved word |
| carry_out | output | 1 | Bit pushed out of the word, or 0 in pass-through mode |

## Verification
The bench builds two copies of the unit side by side, one at the default WIDTH of 8 and one at WIDTH 3, and drives both from the same stimulus. At 8 bits every data value, both carry values and all eight modes are applied exhaustively. The 3-bit copy uses an odd width, which moves the top-bit position away from a byte boundary, so an index tied to a fixed width would show up as a mismatch. Each item is checked in the same cycle it is driven, which covers R10.

// File: rtl/step_shift_pkg.sv
// Package: shared mode encoding for the single-step shift unit.
// Assumes mode bit 2 is the direction bit (1 = right) and 3'b000 is pass-through.
package step_shift_pkg;

    typedef enum logic [2:0] {
        MV_PASS     = 3'b000,
        MV_ROT_L    = 3'b001,
        MV_ZERO_L   = 3'b010,
        MV_CARRY_L  = 3'b011,
        MV_ROT_R    = 3'b100,
        MV_ZERO_R   = 3'b101,
        MV_SIGN_R   = 3'b110,
        MV_CARRY_R  = 3'b111
    } move_mode_e;

endpackage

// File: rtl/step_shift_left.sv
// Module: moves a word left by one position; the fill entering bit 0 is
// chosen by the low two mode bits (rotate, zero, carry-in).
// Assumes WIDTH >= 2; the caller ignores the result for non-left modes.
module step_shift_left
    import step_shift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] word_i,
    input  logic             cin_i,
    input  move_mode_e       mode_i,
    output logic [WIDTH-1:0] word_o,
    output logic             lost_o
);

    localparam int TOP = WIDTH - 1;

    logic fill_bit;

    // Pick the bit that enters at the low end.
    always_comb begin
        unique case (mode_i)
            MV_ROT_L:   fill_bit = word_i[TOP];
            MV_CARRY_L: fill_bit = cin_i;
            default:    fill_bit = 1'b0;
        endcase
    end

    // Form the moved word and the bit pushed out at the top.
    always_comb begin
        word_o = {word_i[TOP-1:0], fill_bit};
        lost_o = word_i[TOP];
    end

    // A rotate keeps the number of set bits.
    always_comb begin
        if (mode_i == MV_ROT_L) begin
            p_rotl_keeps_ones_r2: assert ($countones(word_o) == $countones(word_i))
                else $error("left rotate changed the number of ones");
        end
    end

endmodule

// File: rtl/step_shift_right.sv
// Module: moves a word right by one position; the fill entering the top bit
// is chosen by the low two mode bits (rotate, zero, sign, carry-in).
// Assumes WIDTH >= 2; the caller ignores the result for non-right modes.
module step_shift_right
    import step_shift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] word_i,
    input  logic             cin_i,
    input  move_mode_e       mode_i,
    output logic [WIDTH-1:0] word_o,
    output logic             lost_o
);

    localparam int TOP = WIDTH - 1;

    logic fill_bit;

    // Pick the bit that enters at the high end.
    always_comb begin
        unique case (mode_i)
            MV_ROT_R:   fill_bit = word_i[0];
            MV_SIGN_R:  fill_bit = word_i[TOP];
            MV_CARRY_R: fill_bit = cin_i;
            default:    fill_bit = 1'b0;
        endcase
    end

    // Form the moved word and the bit pushed out at the bottom.
    always_comb begin
        word_o = {fill_bit, word_i[TOP:1]};
        lost_o = word_i[0];
    end

    // Guard the fill rules for the right-moving modes.
    always_comb begin
        if (mode_i == MV_ROT_R) begin
            p_rotr_keeps_ones_r5: assert ($countones(word_o) == $countones(word_i))
                else $error("right rotate changed the number of ones");
        end
        if (mode_i == MV_ZERO_R) begin
            p_lsr_top_clear_r6: assert (word_o[TOP] == 1'b0)
                else $error("logical right move left a set top bit");
        end
        if (mode_i == MV_SIGN_R) begin
            p_asr_sign_kept_r7: assert (word_o[TOP] == word_i[TOP] && word_o[TOP-1] == word_i[TOP])
                else $error("arithmetic right move lost the sign");
        end
    end

endmodule

// File: rtl/step_shifter.sv
// Module: top of the single-step shift unit. Routes the word through the
// left or right mover and selects the result by the mode's direction bit.
// Assumes WIDTH >= 2. Purely combinational: no clock, no reset, no state.
module step_shifter
    import step_shift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic             carry_in,
    input  logic [2:0]       mode,
    output logic [WIDTH-1:0] data_out,
    output logic             carry_out
);

    localparam int TOP = WIDTH - 1;

    move_mode_e       op;
    logic [WIDTH-1:0] left_word;
    logic [WIDTH-1:0] right_word;
    logic             left_lost;
    logic             right_lost;

    // Give the raw mode code its enumerated type.
    always_comb op = move_mode_e'(mode);

    step_shift_left #(.WIDTH(WIDTH)) u_left (
        .word_i (data_in),
        .cin_i  (carry_in),
        .mode_i (op),
        .word_o (left_word),
        .lost_o (left_lost)
    );

    step_shift_right #(.WIDTH(WIDTH)) u_right (
        .word_i (data_in),
        .cin_i  (carry_in),
        .mode_i (op),
        .word_o (right_word),
        .lost_o (right_lost)
    );

    // Select pass-through, the left result or the right result.
    always_comb begin
        if (op == MV_PASS) begin
            data_out  = data_in;
            carry_out = 1'b0;
        end else if (mode[2]) begin
            data_out  = right_word;
            carry_out = right_lost;
        end else begin
            data_out  = left_word;
            carry_out = left_lost;
        end
    end

    // Check the selected outputs against the inputs across the sub-units.
    always_comb begin
        if (op == MV_PASS) begin
            p_pass_clean_r1: assert (data_out == data_in && carry_out == 1'b0)
                else $error("pass-through altered the word or carry");
        end
        if (mode[2]) begin
            p_right_carry_lsb_r8: assert (carry_out == data_in[0])
                else $error("right move carry is not the old low bit");
        end
        if (op != MV_PASS && !mode[2]) begin
            p_left_carry_msb_r3: assert (carry_out == data_in[TOP])
                else $error("left move carry is not the old top bit");
        end
    end

endmodule

// File: tb/step_shifter_bench.sv
// Scoreboard bench: a driver task applies stimulus and queues the expected
// results; a monitor process pops and compares them on the falling edge.
module step_shifter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [7:0] exp8;
        logic       expc8;
        logic [2:0] exp3;
        logic       expc3;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = '0;
    logic       cin = 1'b0;
    logic [2:0] md = '0;
    logic [7:0] dout8;
    logic       cout8;
    logic [2:0] dout3;
    logic       cout3;

    item_t q[$];
    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    step_shifter #(.WIDTH(8)) u_step_shifter (
        .data_in (din), .carry_in (cin), .mode (md),
        .data_out (dout8), .carry_out (cout8)
    );

    step_shifter #(.WIDTH(3)) u_step_shifter_w3 (
        .data_in (din[2:0]), .carry_in (cin), .mode (md),
        .data_out (dout3), .carry_out (cout3)
    );

    // Requirement model: move a w-bit value by one place per the mode table.
    function automatic logic [8:0] model(input logic [7:0] d, input logic c,
                                         input logic [2:0] m, input int w);
        logic [7:0] mask = 8'((9'd1 << w) - 1);
        logic [7:0] v    = d & mask;
        logic       hi   = v[w-1];
        logic       lo   = v[0];
        logic [7:0] sl   = (v << 1) & mask;
        logic [7:0] sr   = v >> 1;
        logic [7:0] tb   = 8'(1 << (w-1));
        case (m)
            3'd0: return {1'b0, v};
            3'd1: return {hi, sl | {7'd0, hi}};
            3'd2: return {hi, sl};
            3'd3: return {hi, sl | {7'd0, c}};
            3'd4: return {lo, sr | (lo ? tb : 8'd0)};
            3'd5: return {lo, sr};
            3'd6: return {lo, sr | (hi ? tb : 8'd0)};
            default: return {lo, sr | (c ? tb : 8'd0)};
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] m, input logic c);
        if (c && m != 3'd3 && m != 3'd7) return "R9";
        case (m)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Driver: apply one stimulus at the rising edge and queue its expectation.
    task automatic drive(input logic [7:0] d, input logic c, input logic [2:0] m,
                         input string tag);
        item_t it;
        logic [8:0] r8, r3;
        @(posedge clk);
        din = d; cin = c; md = m;
        r8 = model(d, c, m, 8);
        r3 = model(d, c, m, 3);
        it.exp8 = r8[7:0]; it.expc8 = r8[8];
        it.exp3 = r3[2:0]; it.expc3 = r3[8];
        it.tag  = tag;
        q.push_back(it);
    endtask

    // Monitor: compare settled outputs in the same cycle (R10) at the falling edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_checks++;
            if (dout8 !== it.exp8 || cout8 !== it.expc8) begin
                n_fails++;
                $display("FAIL %s w8 din=%h cin=%b mode=%b: got %h/%b expected %h/%b",
                         it.tag, din, cin, md, dout8, cout8, it.exp8, it.expc8);
            end
            n_checks++;
            if (dout3 !== it.exp3 || cout3 !== it.expc3) begin
                n_fails++;
                $display("FAIL %s w3 din=%h cin=%b mode=%b: got %h/%b expected %h/%b",
                         it.tag, din[2:0], cin, md, dout3, cout3, it.exp3, it.expc3);
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // Stimulus: reset phase, corner patterns, then exhaustive sweep.
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Quiet state after reset: zero word in pass mode gives zero (R1).
        drive(8'h00, 1'b0, 3'd0, "R1");
        // Corner words: R2 rotate of 80, R5 rotate of 01, R7 sign of 80.
        drive(8'h80, 1'b0, 3'd1, "R2");
        drive(8'h01, 1'b0, 3'd4, "R5");
        drive(8'h80, 1'b0, 3'd6, "R7");
        drive(8'hFF, 1'b0, 3'd2, "R3");
        drive(8'h00, 1'b1, 3'd3, "R4");
        drive(8'hFF, 1'b0, 3'd5, "R6");
        drive(8'h00, 1'b1, 3'd7, "R8");
        drive(8'hA5, 1'b1, 3'd0, "R9");
        for (int d = 0; d < 256; d++) begin
            for (int c = 0; c < 2; c++) begin
                for (int m = 0; m < 8; m++) begin
                    drive(8'(d), 1'(c), 3'(m), req_of(3'(m), 1'(c)));
                end
            end
        end
        repeat (2) @(posedge clk);
        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule